// File: doc/BRIEF.md
# Multi-Mode LUT Slice Element

This block is one table/storage pair of a programmable logic slice. Sixteen storage bits, addressed by four select inputs, serve one of three roles picked by a two-bit mode field. As a fixed truth table they realise any function of the four select inputs. As a 16x1 memory they take single-bit writes on the clock edge and are read combinationally. As a 16-bit shift register they take a new bit in at the low end and offer any bit as a tap, with the top bit also driven out for chaining.

The table output feeds a storage element. That element can be an edge-triggered flip-flop or a level-sensitive latch, or it can be skipped so the table output reaches the slice output directly. Its clock enable, set and clear inputs can each be inverted. Set and clear can each act at once (asynchronous) or only when the element captures (synchronous). The initial table contents come from a configuration word loaded on a strobe.

Top module: `lut_slice_elem`

## Requirements
- R1: While rst_n is low, all 16 table bits and the storage element are cleared, so lut_out, q_out and casc_out read 0.
- R2: On a rising clock edge with cfg_load high, table bit k takes cfg_word[k] for every k. This takes priority over any write or shift on the same edge.
- R3: lut_out always equals table bit number sel, with no clock needed. In logic mode (cfg_mode = 0, also 3) the we input has no effect on the table.
- R4: In memory mode (cfg_mode = 1), a rising edge with we high and cfg_load low stores din into table bit sel. The other bits are unchanged.
- R5: In shift mode (cfg_mode = 2), a rising edge with we high and cfg_load low moves every table bit k to bit k+1 and puts din in bit 0. casc_out always shows table bit 15.
- R6: In flip-flop form (st_latch = 0), q_out takes lut_out on a rising edge when the effective enable is 1, and holds when it is 0.
- R7: In latch form (st_latch = 1), the element follows lut_out while clk is high and the effective enable is 1. It holds while clk is low.
- R8: Each of set and clear is asynchronous when its style bit (set_async, clr_async) is 1 and acts on q_out at once. When the bit is 0 it is synchronous and acts only at a capture (rising edge, or clk high for the latch), whatever the enable.
- R9: When effective set and effective clear are both active in the same style, clear wins and the element holds 0.
- R10: Each control is used true when its invert bit (ce_inv, set_inv, clr_inv) is 0 and inverted when the bit is 1: effective value = input XOR invert bit.
- R11: With st_bypass = 1, q_out equals lut_out combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; also the latch gate |
| rst_n | input | 1 | Asynchronous active-low reset of table and storage |
| cfg_load | input | 1 | Strobe that loads cfg_word into the table |
| cfg_word | input | 16 | Table contents to load, bit k for select value k |
| cfg_mode | input | 2 | 0 logic, 1 memory, 2 shift, 3 treated as logic |
| st_latch | input | 1 | 1 selects latch form, 0 flip-flop |
| st_bypass | input | 1 | 1 routes lut_out straight to q_out |
| set_async | input | 1 | 1 makes set asynchronous |
| clr_async | input | 1 | 1 makes clear asynchronous |
| ce_inv | input | 1 | Invert the clock enable |
| set_inv | input | 1 | Invert the set input |
| clr_inv | input | 1 | Invert the clear input |
| sel | input | 4 | Table address / tap select |
| din | input | 1 | Write data or shift-in bit |
| we | input | 1 | Write or shift enable |
| ce | input | 1 | Storage clock enable |
| set_in | input | 1 | Storage set |
| clr_in | input | 1 | Storage clear |
| lut_out | output | 1 | Table bit at sel |
| q_out | output | 1 | Storage element or bypassed table output |
| casc_out | output | 1 | Table bit 15 for chaining |

## Verification
lut_out, the bypassed q_out and asynchronous set or clear respond in the same time step, so the bench checks them 1 ns after driving, with no clock edge between. Table loads, writes, shifts and flip-flop captures land on the next rising edge. Their inputs are driven just after a falling edge and the result is read at the following falling edge, half a period after the edge that commits it. Latch behaviour is checked 1 ns after the rising edge, for transparency, and 1 ns after the falling edge, for hold.

// File: rtl/lut_slice_pkg.sv
package lut_slice_pkg;
    typedef enum logic [1:0] {
        MODE_LOGIC = 2'd0,
        MODE_RAM   = 2'd1,
        MODE_SHIFT = 2'd2,
        MODE_RSVD  = 2'd3
    } tbl_mode_e;

    // effective storage controls after polarity selection
    typedef struct packed {
        logic ce;
        logic set;
        logic clr;
    } st_ctrl_s;

    localparam int CTRL_N = 3;
endpackage

// File: rtl/lut_slice_table.sv
module lut_slice_table
    import lut_slice_pkg::*;
#(
    parameter  int SEL_W = 4,
    localparam int DEPTH = 1 << SEL_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  tbl_mode_e        mode,
    input  logic             cfg_load,
    input  logic [DEPTH-1:0] cfg_word,
    input  logic [SEL_W-1:0] sel,
    input  logic             din,
    input  logic             we,
    output logic             lut_out,
    output logic             casc_out
);
    typedef struct packed {
        logic [DEPTH-1:0] bits;
    } tbl_state_s;

    tbl_state_s st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (cfg_load) begin
            st_d.bits = cfg_word;
        end else if (we) begin
            case (mode)
                MODE_RAM:   st_d.bits[sel] = din;
                MODE_SHIFT: st_d.bits = {st_q.bits[DEPTH-2:0], din};
                default:    st_d = st_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign lut_out  = st_q.bits[sel];
    assign casc_out = st_q.bits[DEPTH-1];
endmodule

// File: rtl/lut_slice_pol.sv
module lut_slice_pol
    import lut_slice_pkg::*;
(
    input  logic [CTRL_N-1:0] raw,
    input  logic [CTRL_N-1:0] inv,
    output st_ctrl_s          eff
);
    logic [CTRL_N-1:0] flip;

    for (genvar i = 0; i < CTRL_N; i++) begin : g_pol
        assign flip[i] = raw[i] ^ inv[i];
    end

    assign eff = st_ctrl_s'(flip);
endmodule

// File: rtl/lut_slice_store.sv
module lut_slice_store
    import lut_slice_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     d,
    input  st_ctrl_s ctl,
    input  logic     use_latch,
    input  logic     set_async,
    input  logic     clr_async,
    output logic     q
);
    typedef struct packed {
        logic ff;
        logic lat;
    } st_state_s;

    st_state_s st_d, st_q;
    logic async_clr, async_pre, sync_clr, sync_set, gate_open;

    assign async_clr = ctl.clr & clr_async;
    assign async_pre = ctl.set & set_async & ~async_clr;
    assign sync_clr  = ctl.clr & ~clr_async;
    assign sync_set  = ctl.set & ~set_async;
    assign gate_open = clk & (ctl.ce | sync_clr | sync_set);

    always_comb begin
        st_d = st_q;
        if (sync_clr)      st_d.ff = 1'b0;
        else if (sync_set) st_d.ff = 1'b1;
        else if (ctl.ce)   st_d.ff = d;
        if (sync_clr)      st_d.lat = 1'b0;
        else if (sync_set) st_d.lat = 1'b1;
        else               st_d.lat = d;
    end

    always_ff @(posedge clk or negedge rst_n or posedge async_clr or posedge async_pre) begin
        if (!rst_n)         st_q.ff <= 1'b0;
        else if (async_clr) st_q.ff <= 1'b0;
        else if (async_pre) st_q.ff <= 1'b1;
        else                st_q.ff <= st_d.ff;
    end

    always_latch begin
        if (!rst_n)         st_q.lat <= 1'b0;
        else if (async_clr) st_q.lat <= 1'b0;
        else if (async_pre) st_q.lat <= 1'b1;
        else if (gate_open) st_q.lat <= st_d.lat;
    end

    assign q = use_latch ? st_q.lat : st_q.ff;
endmodule

// File: rtl/lut_slice_elem.sv
module lut_slice_elem
    import lut_slice_pkg::*;
#(
    parameter  int SEL_W = 4,
    localparam int DEPTH = 1 << SEL_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_load,
    input  logic [DEPTH-1:0] cfg_word,
    input  logic [1:0]       cfg_mode,
    input  logic             st_latch,
    input  logic             st_bypass,
    input  logic             set_async,
    input  logic             clr_async,
    input  logic             ce_inv,
    input  logic             set_inv,
    input  logic             clr_inv,
    input  logic [SEL_W-1:0] sel,
    input  logic             din,
    input  logic             we,
    input  logic             ce,
    input  logic             set_in,
    input  logic             clr_in,
    output logic             lut_out,
    output logic             q_out,
    output logic             casc_out
);
    st_ctrl_s ctl;
    logic     store_q;

    lut_slice_table #(.SEL_W(SEL_W)) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode     (tbl_mode_e'(cfg_mode)),
        .cfg_load (cfg_load),
        .cfg_word (cfg_word),
        .sel      (sel),
        .din      (din),
        .we       (we),
        .lut_out  (lut_out),
        .casc_out (casc_out)
    );

    lut_slice_pol u_pol (
        .raw ({ce, set_in, clr_in}),
        .inv ({ce_inv, set_inv, clr_inv}),
        .eff (ctl)
    );

    lut_slice_store u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .d         (lut_out),
        .ctl       (ctl),
        .use_latch (st_latch),
        .set_async (set_async),
        .clr_async (clr_async),
        .q         (store_q)
    );

    assign q_out = st_bypass ? lut_out : store_q;
endmodule

// File: rtl/lut_slice_elem_chk.sv
module lut_slice_elem_chk #(
    parameter  int SEL_W = 4,
    localparam int DEPTH = 1 << SEL_W
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_load,
    input logic [DEPTH-1:0] cfg_word,
    input logic [1:0]       cfg_mode,
    input logic             st_bypass,
    input logic             set_async,
    input logic             clr_async,
    input logic             set_inv,
    input logic             clr_inv,
    input logic [SEL_W-1:0] sel,
    input logic             din,
    input logic             we,
    input logic             set_in,
    input logic             clr_in,
    input logic             lut_out,
    input logic             q_out
);
    logic [DEPTH-1:0] word_q;

    always_ff @(posedge clk) word_q <= cfg_word;

    // R2
    cfg_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_load |=> (lut_out == word_q[sel]));

    // R3
    logic_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_mode == 2'd0 && !cfg_load) |=>
        ((sel != $past(sel)) || (lut_out == $past(lut_out))));

    // R4
    ram_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_mode == 2'd1 && we && !cfg_load) |=>
        ((sel != $past(sel)) || (lut_out == $past(din))));

    // R5
    shift_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_mode == 2'd2 && we && !cfg_load) |=>
        ((sel != '0) || (lut_out == $past(din))));

    // R9
    clr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_bypass && set_async && clr_async &&
         (set_in ^ set_inv) && (clr_in ^ clr_inv)) |-> (q_out == 1'b0));
endmodule

bind lut_slice_elem lut_slice_elem_chk #(.SEL_W(SEL_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_load  (cfg_load),
    .cfg_word  (cfg_word),
    .cfg_mode  (cfg_mode),
    .st_bypass (st_bypass),
    .set_async (set_async),
    .clr_async (clr_async),
    .set_inv   (set_inv),
    .clr_inv   (clr_inv),
    .sel       (sel),
    .din       (din),
    .we        (we),
    .set_in    (set_in),
    .clr_in    (clr_in),
    .lut_out   (lut_out),
    .q_out     (q_out)
);

// File: tb/lut_slice_elem_bench.sv
module lut_slice_elem_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_load = 1'b0;
    logic [15:0] cfg_word = '0;
    logic [1:0]  cfg_mode = 2'd0;
    logic        st_latch = 1'b0, st_bypass = 1'b0;
    logic        set_async = 1'b0, clr_async = 1'b0;
    logic        ce_inv = 1'b0, set_inv = 1'b0, clr_inv = 1'b0;
    logic [3:0]  sel = '0;
    logic        din = 1'b0, we = 1'b0, ce = 1'b0, set_in = 1'b0, clr_in = 1'b0;
    logic        lut_out, q_out, casc_out;

    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    lut_slice_elem u_lut_slice_elem (
        .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_word(cfg_word),
        .cfg_mode(cfg_mode), .st_latch(st_latch), .st_bypass(st_bypass),
        .set_async(set_async), .clr_async(clr_async), .ce_inv(ce_inv),
        .set_inv(set_inv), .clr_inv(clr_inv), .sel(sel), .din(din), .we(we),
        .ce(ce), .set_in(set_in), .clr_in(clr_in), .lut_out(lut_out),
        .q_out(q_out), .casc_out(casc_out)
    );

    typedef struct packed {
        logic [15:0] word;
        logic [3:0]  addr;
        logic        expect_bit;
    } vec_s;

    localparam int NVEC = 12;
    localparam vec_s VECS [NVEC] = '{
        '{16'h8000, 4'd15, 1'b1}, '{16'h8000, 4'd14, 1'b0},
        '{16'h6996, 4'd0,  1'b0}, '{16'h6996, 4'd1,  1'b1},
        '{16'h6996, 4'd3,  1'b0}, '{16'h6996, 4'd7,  1'b1},
        '{16'hFFFE, 4'd0,  1'b0}, '{16'hFFFE, 4'd8,  1'b1},
        '{16'hCACA, 4'd1,  1'b1}, '{16'hCACA, 4'd2,  1'b0},
        '{16'hCACA, 4'd6,  1'b1}, '{16'hCACA, 4'd5,  1'b0}
    };

    task automatic chk(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic nedge();
        @(negedge clk);
    endtask

    task automatic load(input logic [15:0] w);
        cfg_word = w; cfg_load = 1'b1;
        nedge();
        cfg_load = 1'b0;
    endtask

    initial begin
        #(20 * 50000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) nedge();
        // R1: reset state
        for (int s = 0; s < 16; s += 5) begin
            sel = 4'(s); #1;
            chk("R1 lut_out", lut_out, 1'b0);
        end
        chk("R1 q_out", q_out, 1'b0);
        chk("R1 casc_out", casc_out, 1'b0);
        rst_n = 1'b1;
        nedge();

        // R2 / R3: truth-table vectors
        for (int i = 0; i < NVEC; i++) begin
            sel = VECS[i].addr;
            load(VECS[i].word);
            #1 chk("R2 R3 table read", lut_out, VECS[i].expect_bit);
        end

        // R3: we ignored in logic mode
        load(16'h6996);
        sel = 4'd0; din = 1'b1; we = 1'b1;
        nedge(); we = 1'b0; #1;
        chk("R3 we ignored", lut_out, 1'b0);

        // R2: load beats a write on the same edge
        cfg_mode = 2'd1; sel = 4'd0; din = 1'b1; we = 1'b1;
        load(16'h0000);
        we = 1'b0; #1;
        chk("R2 load priority", lut_out, 1'b0);

        // R4: memory writes and asynchronous reads
        sel = 4'd5; din = 1'b1; we = 1'b1;
        nedge(); we = 1'b0; #1;
        chk("R4 write 1", lut_out, 1'b1);
        sel = 4'd4; #1 chk("R4 neighbour low", lut_out, 1'b0);
        sel = 4'd6; #1 chk("R4 neighbour high", lut_out, 1'b0);
        sel = 4'd5; din = 1'b0; we = 1'b1;
        nedge(); we = 1'b0; #1;
        chk("R4 write 0", lut_out, 1'b0);

        // R5: shift register walk
        cfg_mode = 2'd2;
        load(16'h0000);
        din = 1'b1; we = 1'b1;
        nedge(); din = 1'b0; #1;
        sel = 4'd0; #1 chk("R5 shift in", lut_out, 1'b1);
        repeat (15) nedge();
        we = 1'b0; #1;
        chk("R5 cascade", casc_out, 1'b1);
        sel = 4'd15; #1 chk("R5 tap 15", lut_out, 1'b1);
        sel = 4'd14; #1 chk("R5 tap 14", lut_out, 1'b0);
        nedge(); #1 chk("R5 hold without we", casc_out, 1'b1);
        we = 1'b1; nedge(); we = 1'b0; #1;
        chk("R5 shifted out", casc_out, 1'b0);

        // R6: flip-flop capture and hold
        cfg_mode = 2'd0;
        load(16'h0002);
        sel = 4'd1; ce = 1'b1;
        nedge(); #1 chk("R6 capture", q_out, 1'b1);
        sel = 4'd0; ce = 1'b0;
        nedge(); #1 chk("R6 hold", q_out, 1'b1);
        ce = 1'b1;
        nedge(); #1 chk("R6 capture 0", q_out, 1'b0);

        // R10: inverted enable
        ce_inv = 1'b1; sel = 4'd1;
        nedge(); #1 chk("R10 ce inverted blocks", q_out, 1'b0);
        ce = 1'b0;
        nedge(); #1 chk("R10 ce inverted passes", q_out, 1'b1);
        ce_inv = 1'b0; ce = 1'b1;

        // R8: synchronous clear
        clr_in = 1'b1; #1;
        chk("R8 sync clear waits", q_out, 1'b1);
        nedge(); #1 chk("R8 sync clear at edge", q_out, 1'b0);
        clr_in = 1'b0;
        nedge(); #1 chk("R6 recapture", q_out, 1'b1);

        // R8: asynchronous clear
        clr_async = 1'b1; clr_in = 1'b1; #1;
        chk("R8 async clear", q_out, 1'b0);
        clr_in = 1'b0;
        nedge(); #1 chk("R8 after async clear", q_out, 1'b1);

        // R8: synchronous set
        sel = 4'd0;
        nedge(); #1 chk("R6 capture 0 again", q_out, 1'b0);
        set_in = 1'b1; #1;
        chk("R8 sync set waits", q_out, 1'b0);
        nedge(); #1 chk("R8 sync set at edge", q_out, 1'b1);
        set_in = 1'b0;
        nedge(); #1 chk("R6 back to 0", q_out, 1'b0);

        // R8 / R9: asynchronous set, then clear on top of it
        set_async = 1'b1; set_in = 1'b1; #1;
        chk("R8 async set", q_out, 1'b1);
        clr_in = 1'b1; #1;
        chk("R9 async clear wins", q_out, 1'b0);
        nedge(); #1 chk("R9 async clear wins at edge", q_out, 1'b0);
        set_in = 1'b0; clr_in = 1'b0;
        set_async = 1'b0; clr_async = 1'b0;

        // R9: synchronous set and clear together
        sel = 4'd1;
        nedge(); #1 chk("R6 capture 1", q_out, 1'b1);
        set_in = 1'b1; clr_in = 1'b1;
        nedge(); #1 chk("R9 sync clear wins", q_out, 1'b0);
        set_in = 1'b0; clr_in = 1'b0;
        nedge(); #1 chk("R6 capture 1 again", q_out, 1'b1);

        // R10: inverted clear input
        clr_in = 1'b1; clr_inv = 1'b1;
        nedge(); #1 chk("R10 clr inverted idle", q_out, 1'b1);
        clr_in = 1'b0;
        nedge(); #1 chk("R10 clr inverted active", q_out, 1'b0);
        clr_inv = 1'b0;

        // R7: latch transparency and hold
        st_latch = 1'b1; sel = 4'd0;
        @(posedge clk); #1 chk("R7 transparent 0", q_out, 1'b0);
        @(negedge clk); #1;
        sel = 4'd1; #1 chk("R7 hold low phase", q_out, 1'b0);
        @(posedge clk); #1 chk("R7 transparent 1", q_out, 1'b1);
        @(negedge clk); #1;
        sel = 4'd0; #1 chk("R7 hold after close", q_out, 1'b1);

        // R11: bypass
        st_bypass = 1'b1; #1;
        chk("R11 bypass 0", q_out, 1'b0);
        sel = 4'd1; #1 chk("R11 bypass 1", q_out, 1'b1);

        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule